// File: doc/BRIEF.md
# Serial Digit Timing Generator

This block derives the whole timing skeleton of a bit-serial decimal arithmetic machine from a single fast clock. Each clock is one phase slot. Three phase slots form one bit time. Four bit times form one decimal digit, and sixteen digits form one number cycle. Registers elsewhere on the chip shift one bit for each bit time. They capture data in the first phase, change outputs in the second phase, and use the third phase for elements that need an extra step.

The block drives three phase strobes, a one-hot bit vector and a one-hot digit vector. It also decodes two strobes from particular slots. The first is a trigger used to advance digit-rate logic and to latch the display. The second is a capture pulse that marks the last bit of the last digit of every number cycle. The only inputs are the clock and a synchronous reset.

Top module: `serial_digit_timer`

## Requirements
- R1: `phase_o` has exactly one bit high on every clock out of reset, and the bits take turns in the order bit 0 (capture), bit 1 (output transition), bit 2 (auxiliary), then back to bit 0.
- R2: `bit_o` bit i is the i-th bit time of a digit, with weights 1, 2, 4, 8 for i = 0..3. The vector moves to the next index on the clock that follows a `phase_o[2]` cycle, it holds otherwise, and it wraps from index 3 to index 0.
- R3: `digit_o` bit j is digit time j+1 (j = 0..15). The vector moves to the next index on the clock that follows the cycle where both `phase_o[2]` and `bit_o[3]` are high, it holds otherwise, and it wraps from index 15 to index 0.
- R4: `digit_trig_o` is high for exactly the whole of bit times 0 and 2 of every digit, and low in bit times 1 and 3.
- R5: `cycle_end_o` is high for exactly the bit time where `digit_o[15]` and `bit_o[3]` are both high, and low at all other times.
- R6: While `rst` is high at a clock edge, the next state shows `phase_o` = 001, `bit_o` = 0001 and `digit_o` = bit 0 only. This holds whatever the timing state was before.
- R7: Out of reset, exactly one bit of `bit_o` and exactly one bit of `digit_o` are high.
- R8: Successive rising edges of `cycle_end_o` are 192 clocks apart (3 × 4 × 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| phase_o | output | 3 | One-hot master phase strobes |
| bit_o | output | 4 | One-hot bit time within the digit |
| digit_o | output | 16 | One-hot digit time within the number cycle |
| digit_trig_o | output | 1 | Trigger strobe during bit times 0 and 2 |
| cycle_end_o | output | 1 | Capture pulse during the last bit of the last digit |

## Verification
Two things happen in the same clock at the end of each number cycle: the bit counter wraps and the digit counter wraps. The final clock of the capture pulse is also the auxiliary phase of bit 3 in digit 16. The bench runs the generator freely through more than two full number cycles so that this wrap recurs, and the scoreboard compares every output field on every clock with values computed from the cycle index. A reset applied in the middle of a cycle checks that the state recovers from an arbitrary point.

// File: rtl/serial_digit_timer.sv
module serial_digit_timer #(
  parameter int PHASES = 3,
  parameter int BITS   = 4,
  parameter int DIGITS = 16,
  parameter int TRIG_A = 0,
  parameter int TRIG_B = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PHASES-1:0] phase_o,
  output logic [BITS-1:0]   bit_o,
  output logic [DIGITS-1:0] digit_o,
  output logic              digit_trig_o,
  output logic              cycle_end_o
);
  localparam int PHW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PHW-1:0] ph_q;
  logic           last_ph;
  logic           bit_wrap;

  assign last_ph  = (ph_q == PHW'(PHASES - 1));
  assign bit_wrap = last_ph & bit_o[BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      bit_o   <= BITS'(1);
      digit_o <= DIGITS'(1);
    end else begin
      ph_q <= last_ph ? '0 : ph_q + 1'b1;
      if (last_ph)
        bit_o <= {bit_o[BITS-2:0], bit_o[BITS-1]};
      if (bit_wrap)
        digit_o <= {digit_o[DIGITS-2:0], digit_o[DIGITS-1]};
    end
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign phase_o[i] = (ph_q == PHW'(i));
    p_phase_next_r1: assert property (@(posedge clk) disable iff (rst)
      phase_o[i] |=> phase_o[(i + 1) % PHASES]);
  end

  assign digit_trig_o = bit_o[TRIG_A] | bit_o[TRIG_B];
  assign cycle_end_o  = digit_o[DIGITS-1] & bit_o[BITS-1];

  p_phase_one_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !phase_o[PHASES-1] |=> $stable(bit_o));
  p_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
    phase_o[PHASES-1] |=> bit_o == {$past(bit_o[BITS-2:0]), $past(bit_o[BITS-1])});
  p_digit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(phase_o[PHASES-1] && bit_o[BITS-1]) |=> $stable(digit_o));
  p_trig_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(digit_trig_o) |-> phase_o[0]);
  p_end_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cycle_end_o) |-> phase_o[0] && $past(digit_o[DIGITS-1]));
  p_end_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    cycle_end_o && phase_o[PHASES-1] |=> digit_o[0] && bit_o[0] && !cycle_end_o);
  p_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(bit_o) == 1);
  p_one_digit_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(digit_o) == 1);
endmodule

// File: tb/serial_digit_timer_tb.sv
module serial_digit_timer_tb;
  typedef struct packed {
    logic [2:0]  ph;
    logic [3:0]  bt;
    logic [15:0] dg;
    logic        trig;
    logic        eoc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  phase_o;
  logic [3:0]  bit_o;
  logic [15:0] digit_o;
  logic        digit_trig_o;
  logic        cycle_end_o;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  serial_digit_timer u_dut (
    .clk(clk), .rst(rst), .phase_o(phase_o), .bit_o(bit_o),
    .digit_o(digit_o), .digit_trig_o(digit_trig_o), .cycle_end_o(cycle_end_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_expect(input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int p, b, d;
      p = k % 3; b = (k / 3) % 4; d = (k / 12) % 16;
      e.ph   = 3'(1 << p);
      e.bt   = 4'(1 << b);
      e.dg   = 16'(1 << d);
      e.trig = (b == 0) || (b == 2);
      e.eoc  = (d == 15) && (b == 3);
      q.push_back(e);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R6 phase"}, 32'(phase_o), 32'h1);
    chk({tag, " R6 bit"}, 32'(bit_o), 32'h1);
    chk({tag, " R6 digit"}, 32'(digit_o), 32'h1);
  endtask

  task automatic monitor_run();
    int last_rise = -1;
    int idx = 0;
    logic prev_eoc = 1'b0;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 phase", 32'(phase_o), 32'(e.ph));
      chk("R2 bit", 32'(bit_o), 32'(e.bt));
      chk("R3 digit", 32'(digit_o), 32'(e.dg));
      chk("R4 trig", 32'(digit_trig_o), 32'(e.trig));
      chk("R5 end", 32'(cycle_end_o), 32'(e.eoc));
      chk("R7 one bit", 32'($countones(bit_o)), 32'd1);
      chk("R7 one digit", 32'($countones(digit_o)), 32'd1);
      if (cycle_end_o && !prev_eoc) begin
        if (last_rise >= 0) chk("R8 period", 32'(idx - last_rise), 32'd192);
        last_rise = idx;
      end
      prev_eoc = cycle_end_o;
      idx++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("initial");
    drive_expect(420);
    rst = 1'b0;
    monitor_run();
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("midrun");
    rst = 1'b0;
    drive_expect(30);
    monitor_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule